// File: doc/BRIEF.md
# Sector Read DMA Controller

This block lets a processor fetch one fixed-size sector of 512 bytes from a local sector store and land it in main memory without moving the data itself. Software programs a logical block number, a destination byte address and an access latency through a small register port. It then writes the read command code. The controller waits out the programmed latency, which stands in for seek and rotation time. It then streams the sector as 32-bit words to a memory write master that uses a valid/ready handshake.

When the last word has been accepted, the controller sets a done flag that drives the interrupt line. Software clears the flag, and with it the interrupt, either by writing a one to the done bit of the status register or by pulsing a dedicated clear input. A block number beyond the store is reported with an error bit instead of a transfer. A command that arrives during a transfer is dropped and flagged as an overrun.

The sector store is built in. Its word contents are computed from the block number and the word index, so the bench needs no memory model.

Top module: `sector_dma`

## Requirements
- R1: Writing a value whose low byte is 0x01 to the command register (offset 0) while the controller is idle starts a transfer, and status bit 0 (busy) reads 1 until the transfer ends. Writing any other code while idle has no effect.
- R2: A transfer writes exactly 128 words, one per handshake, to byte addresses dest, dest+4, dest+8 and so on in ascending order. The two low bits of a value written to the destination register (offset 2) are stored as zero.
- R3: Word i of block b carries the value {b[15:0], i[15:0]} XOR 0x5A5A0000.
- R4: While m_valid is high and m_ready is low, m_valid, m_addr and m_data hold their values. The controller moves to the next word only after a cycle in which both are high.
- R5: The first m_valid rises exactly LAT+2 clock edges after the edge that accepts the command, where LAT is the value in the latency register (offset 3).
- R6: After the last word is accepted, status bit 0 (busy) clears and status bit 1 (done) sets, and irq follows the done bit.
- R7: Writing a value with bit 1 set to the status register (offset 4), or pulsing irq_clr, clears done and irq.
- R8: A command write while busy is ignored and sets status bit 3 (overrun), and the running transfer is unaffected. Writing a value with bit 3 set to status clears the overrun bit.
- R9: A block number of 8 or more, compared over all 32 bits, makes no memory write and raises done, irq and status bit 2 (error) within two edges of the command. The next valid start clears the error bit.
- R10: After reset, irq and m_valid are low, status reads 0 and the block number register reads 0.
- R11: The block number (offset 1), destination (offset 2) and latency (offset 3) registers read back their written values on reg_rdata for the current reg_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| m_valid | output | 1 | Memory write request valid |
| m_addr | output | 32 | Memory write byte address |
| m_data | output | 32 | Memory write data word |
| m_ready | input | 1 | Memory accepts the current word |
| irq | output | 1 | Transfer-complete interrupt |
| irq_clr | input | 1 | Pulse to clear done and irq |

## Verification
The bench applies a pseudo-random m_ready pattern, so a controller that advanced without a handshake, or changed the address or data under a stall, would be caught dropping or repeating words. The latency is measured for both zero and non-zero values, which exposes an off-by-one in the wait counter. A command is issued mid-transfer to catch a design that restarts or corrupts the stream instead of only setting overrun. Block numbers 8 and 0x108 are used because a range check over only the low bits would accept 0x108 as block 0 and stream data.

// File: rtl/sector_dma_pkg.sv
package sector_dma_pkg;
    // register offsets (word granular)
    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_LBA  = 3'd1;
    localparam logic [2:0] OFF_DEST = 3'd2;
    localparam logic [2:0] OFF_LAT  = 3'd3;
    localparam logic [2:0] OFF_STAT = 3'd4;

    localparam logic [7:0]  CMD_READ  = 8'h01;
    localparam logic [31:0] FILL_MASK = 32'h5A5A_0000;

    // status bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;
    localparam int STAT_OVR  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FETCH,
        ST_PUSH,
        ST_FIN
    } eng_state_e;
endpackage

// File: rtl/sdma_store.sv
module sdma_store
    import sector_dma_pkg::*;
#(
    parameter int BLK_W = 3,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [BLK_W-1:0] rd_blk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] data_d, data_q;

    // contents are a function of block and word index: no storage array
    always_comb begin
        data_d = data_q;
        if (rd_en) begin
            data_d = {16'(rd_blk), 16'(rd_idx)} ^ FILL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign rd_data = data_q;
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
    import sector_dma_pkg::*;
#(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             irq_clr,
    input  logic             busy,
    input  logic             fin,
    input  logic             fin_err,
    output logic             start,
    output logic [31:0]      cfg_lba,
    output logic [31:0]      cfg_dest,
    output logic [LAT_W-1:0] cfg_lat,
    output logic [31:0]      reg_rdata,
    output logic             done,
    output logic             ovr
);
    typedef struct packed {
        logic [31:0]      lba;
        logic [31:0]      dest;
        logic [LAT_W-1:0] lat;
        logic             done;
        logic             err;
        logic             ovr;
    } regs_t;

    regs_t q, d;
    logic  wr_cmd;

    always_comb begin
        d      = q;
        wr_cmd = reg_we && (reg_addr == OFF_CMD);
        start  = wr_cmd && (reg_wdata[7:0] == CMD_READ) && !busy;

        if (reg_we) begin
            case (reg_addr)
                OFF_LBA:  d.lba  = reg_wdata;
                OFF_DEST: d.dest = {reg_wdata[31:2], 2'b00};
                OFF_LAT:  d.lat  = reg_wdata[LAT_W-1:0];
                OFF_STAT: begin
                    if (reg_wdata[STAT_DONE]) d.done = 1'b0;
                    if (reg_wdata[STAT_OVR])  d.ovr  = 1'b0;
                end
                default: ;
            endcase
        end
        if (irq_clr)        d.done = 1'b0;
        if (wr_cmd && busy) d.ovr  = 1'b1;
        if (start)          d.err  = 1'b0;
        // completion wins over a clear in the same cycle
        if (fin) begin
            d.done = 1'b1;
            d.err  = fin_err;
        end

        case (reg_addr)
            OFF_LBA:  reg_rdata = q.lba;
            OFF_DEST: reg_rdata = q.dest;
            OFF_LAT:  reg_rdata = 32'(q.lat);
            OFF_STAT: reg_rdata = {28'd0, q.ovr, q.err, q.done, busy};
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_lba  = q.lba;
    assign cfg_dest = q.dest;
    assign cfg_lat  = q.lat;
    assign done     = q.done;
    assign ovr      = q.ovr;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sector_dma_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int WORDS      = 128,
    parameter int LAT_W      = 16,
    parameter int BLK_W      = 3,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      cfg_lba,
    input  logic [31:0]      cfg_dest,
    input  logic [LAT_W-1:0] cfg_lat,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [31:0]      m_addr,
    output logic             busy,
    output logic             fin,
    output logic             fin_err,
    output logic             rd_en,
    output logic [BLK_W-1:0] rd_blk,
    output logic [IDX_W-1:0] rd_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        eng_state_e       st;
        logic [LAT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [31:0]      addr;
        logic [BLK_W-1:0] blk;
        logic             err;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d     = q;
        fin   = 1'b0;
        rd_en = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr = cfg_dest;
                    d.cnt  = cfg_lat;
                    d.idx  = '0;
                    d.blk  = cfg_lba[BLK_W-1:0];
                    if (cfg_lba < 32'(NUM_BLOCKS)) begin
                        d.err = 1'b0;
                        d.st  = ST_WAIT;
                    end else begin
                        d.err = 1'b1;
                        d.st  = ST_FIN;
                    end
                end
            end
            ST_WAIT: begin
                if (q.cnt == '0) d.st  = ST_FETCH;
                else             d.cnt = q.cnt - LAT_W'(1);
            end
            ST_FETCH: begin
                rd_en = 1'b1;
                d.st  = ST_PUSH;
            end
            ST_PUSH: begin
                if (m_ready) begin
                    if (q.idx == LAST_IDX) begin
                        d.st = ST_FIN;
                    end else begin
                        d.idx  = q.idx + IDX_W'(1);
                        d.addr = q.addr + 32'd4;
                        d.st   = ST_FETCH;
                    end
                end
            end
            ST_FIN: begin
                fin  = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign m_valid = (q.st == ST_PUSH);
    assign m_addr  = q.addr;
    assign fin_err = q.err;
    assign rd_blk  = q.blk;
    assign rd_idx  = q.idx;
endmodule

// File: rtl/sector_dma.sv
module sector_dma
    import sector_dma_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int NUM_BLOCKS   = 8,
    parameter int LAT_W        = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        m_valid,
    output logic [31:0] m_addr,
    output logic [31:0] m_data,
    input  logic        m_ready,
    output logic        irq,
    input  logic        irq_clr
);
    localparam int WORDS = SECTOR_BYTES / 4;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

    logic             eng_start, eng_busy, eng_fin, eng_fin_err;
    logic [31:0]      cfg_lba, cfg_dest;
    logic [LAT_W-1:0] cfg_lat;
    logic             st_rd_en;
    logic [BLK_W-1:0] st_blk;
    logic [IDX_W-1:0] st_idx;
    logic             done_flag, ovr_flag;

    sdma_regs #(.LAT_W(LAT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .irq_clr  (irq_clr),
        .busy     (eng_busy),
        .fin      (eng_fin),
        .fin_err  (eng_fin_err),
        .start    (eng_start),
        .cfg_lba  (cfg_lba),
        .cfg_dest (cfg_dest),
        .cfg_lat  (cfg_lat),
        .reg_rdata(reg_rdata),
        .done     (done_flag),
        .ovr      (ovr_flag)
    );

    sdma_engine #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .WORDS     (WORDS),
        .LAT_W     (LAT_W),
        .BLK_W     (BLK_W),
        .IDX_W     (IDX_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .cfg_lba (cfg_lba),
        .cfg_dest(cfg_dest),
        .cfg_lat (cfg_lat),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_addr  (m_addr),
        .busy    (eng_busy),
        .fin     (eng_fin),
        .fin_err (eng_fin_err),
        .rd_en   (st_rd_en),
        .rd_blk  (st_blk),
        .rd_idx  (st_idx)
    );

    sdma_store #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (st_rd_en),
        .rd_blk (st_blk),
        .rd_idx (st_idx),
        .rd_data(m_data)
    );

    assign irq = done_flag;
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker
    import sector_dma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic        irq_clr,
    input logic        m_valid,
    input logic        m_ready,
    input logic [31:0] m_addr,
    input logic [31:0] m_data,
    input logic        irq,
    input logic        busy,
    input logic        start,
    input logic        fin,
    input logic        ovr
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_valid); // R2

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_addr[1:0] == 2'b00)); // R2

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data))); // R4

    AST_IRQ_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> irq); // R6

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fin) |=> !irq); // R7

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == OFF_CMD) && busy) |=> ovr); // R8
endmodule

bind sector_dma sdma_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .irq_clr (irq_clr),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_addr  (m_addr),
    .m_data  (m_data),
    .irq     (irq),
    .busy    (eng_busy),
    .start   (eng_start),
    .fin     (eng_fin),
    .ovr     (ovr_flag)
);

// File: tb/sector_dma_test.sv
`timescale 1ns/1ps
module sector_dma_test;
    localparam int NWORDS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        m_valid;
    logic [31:0] m_addr, m_data;
    logic        m_ready = 1'b1;
    logic        irq;
    logic        irq_clr = 1'b0;

    int checks = 0;
    int failures = 0;
    bit bp_mode = 1'b0;
    logic [63:0] exp_q[$];

    always #2.5 clk = ~clk;

    sector_dma uut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data), .m_ready(m_ready),
        .irq(irq), .irq_clr(irq_clr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // ready pattern: always high, or pseudo-random stalls
    initial begin
        logic [7:0] lfsr = 8'hA1;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            m_ready = bp_mode ? lfsr[0] : 1'b1;
        end
    end

    // scoreboard monitor
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr, hold_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                check(m_valid && m_addr == hold_addr && m_data == hold_data, "R4 stall hold", m_addr, hold_addr);
            hold_pend = m_valid && !m_ready;
            hold_addr = m_addr;
            hold_data = m_data;
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected memory write", m_addr, 32'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check(m_addr == e[63:32], "R2 address", m_addr, e[63:32]);
                    check(m_data == e[31:0], "R3 data", m_data, e[31:0]);
                end
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    // programs a transfer; expected words are queued before the command
    task automatic start_read(input logic [31:0] blk, input logic [31:0] dest,
                              input logic [31:0] lat, input bit in_range);
        reg_write(3'd1, blk);
        reg_write(3'd2, dest);
        reg_write(3'd3, lat);
        if (in_range) begin
            for (int i = 0; i < NWORDS; i++) begin
                logic [31:0] a, dv;
                a  = {dest[31:2], 2'b00} + 32'(4 * i);
                dv = {blk[15:0], 16'(i)} ^ 32'h5A5A_0000;
                exp_q.push_back({a, dv});
            end
        end
        reg_write(3'd0, 32'h0000_0001);
    endtask

    task automatic measure_latency(input int lat, input string req);
        int n = 0;
        forever begin
            @(negedge clk);
            if (m_valid || n > 100) break;
            n++;
        end
        check(n == lat + 2, req, 32'(n), 32'(lat + 2));
    endtask

    task automatic wait_irq(input int limit, input string req);
        int n = 0;
        while (!irq && n < limit) begin
            @(negedge clk);
            n++;
        end
        check(irq == 1'b1, req, 32'(irq), 32'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        check(irq == 1'b0, "R10 irq after reset", 32'(irq), 32'd0);
        check(m_valid == 1'b0, "R10 m_valid after reset", 32'(m_valid), 32'd0);
        reg_read(3'd4, v); check(v == 32'd0, "R10 status after reset", v, 32'd0);
        reg_read(3'd1, v); check(v == 32'd0, "R10 block register after reset", v, 32'd0);

        // R11 readback, R2 alignment of destination
        reg_write(3'd1, 32'd3);
        reg_write(3'd2, 32'h0000_1003);
        reg_write(3'd3, 32'd5);
        reg_read(3'd1, v); check(v == 32'd3, "R11 block readback", v, 32'd3);
        reg_read(3'd2, v); check(v == 32'h0000_1000, "R11 R2 dest readback aligned", v, 32'h0000_1000);
        reg_read(3'd3, v); check(v == 32'd5, "R11 latency readback", v, 32'd5);

        // transfer A: full-rate ready
        start_read(32'd3, 32'h0000_1000, 32'd5, 1'b1);
        measure_latency(5, "R5 latency 5");
        reg_read(3'd4, v); check(v[0] == 1'b1, "R1 busy during transfer", v, 32'd1);
        wait_irq(2000, "R6 irq after transfer");
        reg_read(3'd4, v); check(v == 32'h2, "R6 status done not busy", v, 32'h2);
        check(exp_q.size() == 0, "R2 all words written", 32'(exp_q.size()), 32'd0);

        // R7 clear by status write
        reg_write(3'd4, 32'h2);
        @(negedge clk);
        check(irq == 1'b0, "R7 irq cleared by status write", 32'(irq), 32'd0);
        reg_read(3'd4, v); check(v == 32'd0, "R7 status after clear", v, 32'd0);

        // transfer B: stalls, zero latency, overrun
        bp_mode = 1'b1;
        start_read(32'd7, 32'h8000_0000, 32'd0, 1'b1);
        measure_latency(0, "R5 latency 0");
        reg_write(3'd0, 32'h0000_0001);
        reg_read(3'd4, v); check(v[3] == 1'b1 && v[0] == 1'b1, "R8 overrun while busy", v, 32'h9);
        wait_irq(5000, "R6 irq after stalled transfer");
        check(exp_q.size() == 0, "R8 transfer unaffected by late command", 32'(exp_q.size()), 32'd0);
        bp_mode = 1'b0;
        repeat (4) @(negedge clk);
        check(m_valid == 1'b0, "R8 no restarted transfer", 32'(m_valid), 32'd0);
        @(posedge clk); #1 irq_clr = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R7 irq cleared by pulse", 32'(irq), 32'd0);
        reg_write(3'd4, 32'h8);
        reg_read(3'd4, v); check(v == 32'd0, "R8 overrun cleared", v, 32'd0);

        // R1 other command codes do nothing
        reg_write(3'd0, 32'h0000_0002);
        repeat (10) @(negedge clk);
        reg_read(3'd4, v); check(v == 32'd0, "R1 unknown code ignored", v, 32'd0);
        check(m_valid == 1'b0, "R1 no write after unknown code", 32'(m_valid), 32'd0);

        // R9 out-of-range block
        start_read(32'd8, 32'h0000_2000, 32'd3, 1'b0);
        wait_irq(2, "R9 irq within two edges");
        reg_read(3'd4, v); check(v == 32'h6, "R9 error and done", v, 32'h6);
        reg_write(3'd4, 32'h2);
        start_read(32'h0000_0108, 32'h0000_3000, 32'd3, 1'b0);
        wait_irq(2, "R9 irq for wide block number");
        reg_read(3'd4, v); check(v == 32'h6, "R9 full width range check", v, 32'h6);
        reg_write(3'd4, 32'h2);

        // R9 valid start clears error
        start_read(32'd0, 32'h0000_4000, 32'd1, 1'b1);
        measure_latency(1, "R5 latency 1");
        wait_irq(2000, "R6 irq after block 0");
        reg_read(3'd4, v); check(v == 32'h2, "R9 error cleared by valid start", v, 32'h2);
        check(exp_q.size() == 0, "R2 block 0 all words", 32'(exp_q.size()), 32'd0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule